// File: doc/BRIEF.md
# PWM Compare Register Update Controller

This block holds the four 12-bit compare thresholds of one PWM stage: two for the rising edge (`ra`, `sa`) and two for the falling edge (`rb`, `sb`). The falling-edge `rb` register also carries a 4-bit flank-width field. Software writes them over an 8-bit bus. A 16-bit value is built in a single temporary high-byte register that all four compare registers share. The value is written into the staging set as a whole when its low byte arrives.

The block keeps two copies of the compare set: a staging set that the bus writes, and an active set that drives the outputs. Three configuration bits decide when the staging set is copied into the active set:

- **Hold:** stops all updates.
- **End-of-cycle:** copies only at the PWM counter's end-of-cycle strobe, and only if `rb` was the latest compare register written.
- **Symmetric:** copies the `rb` and `sb` values into the `ra` and `sa` slots, which gives fifty-percent waveforms.

A comparator per active value raises a hit flag when the external counter equals that value.

Top module: `pwm_cmp_update`

## Requirements
- R1: After a synchronous reset, all four active compare outputs and the flank output are zero, and the configuration is zero (free mode). With `cnt` at 0, all four hit flags are 1.
- R2: Address decode works as follows. When `bus_addr[3]` is 1, the byte goes to configuration: bit0 = hold, bit1 = end-of-cycle mode, bit2 = symmetric mode. When `bus_addr[3]` is 0, `bus_addr[2:1]` selects the register (0 = ra, 1 = rb, 2 = sa, 3 = sb). In that case `bus_addr[0]` = 1 writes the byte into the temporary high byte, and `bus_addr[0]` = 0 writes {temporary, byte} into the selected staging register.
- R3: A high-byte write by itself changes no output. The temporary byte is shared by all four registers and is kept after use, so a later low-byte write to any register combines with it.
- R4: In free mode (hold and end-of-cycle both 0), a value whose low byte is captured at clock edge k appears on the active outputs after edge k+1, and not before.
- R5: The ra, sa and sb registers keep bits 11:0 of the written 16-bit value. The rb register keeps bits 11:0 as its compare value and bits 15:12 as the flank-width field, shown on `flank`.
- R6: With hold set and end-of-cycle mode clear, the active set does not change, whether or not the end-of-cycle strobe pulses. After a configuration write that clears hold at edge k, the staged values become active at edge k+1.
- R7: In end-of-cycle mode, the active set changes only at a clock edge where `cyc_end` is 1 and rb was the latest compare register written. A strobe without such an rb write leaves the outputs unchanged.
- R8: In end-of-cycle mode, a write to ra, sa or sb after the rb write cancels the pending commit, so the next strobe changes nothing.
- R9: When hold and end-of-cycle mode are both set, end-of-cycle behaviour applies.
- R10: In symmetric mode, each commit loads the active ra with the staged rb compare value and the active sa with the staged sb value. Values written to ra and sa do not appear.
- R11: `hit[0..3]` correspond to ra, rb, sa, sb in that order. Each flag is 1 exactly when `cnt` equals that active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Bus address |
| bus_wdata | input | 8 | Bus write byte |
| cyc_end | input | 1 | End-of-PWM-cycle strobe from the counter |
| cnt | input | 12 | PWM counter value |
| act_ra | output | 12 | Active rising-edge compare A |
| act_rb | output | 12 | Active falling-edge compare B |
| act_sa | output | 12 | Active rising-edge compare S |
| act_sb | output | 12 | Active falling-edge compare S |
| flank | output | 4 | Active flank-width field |
| hit | output | 4 | Counter-equals-compare flags (ra, rb, sa, sb) |

## Verification
Assertions check on every cycle that:
- hold freezes the active set;
- end-of-cycle mode freezes it except at a strobe;
- a symmetric-mode commit leaves matching rising and falling slots;
- an rb low-byte write arms the pending-commit flag.

Only the bench scenarios can show:
- byte assembly through the shared temporary;
- the one-cycle latency of free mode and of releasing hold;
- the cancelling of a pending commit by a later write;
- the priority of end-of-cycle mode over hold.

Exhaustive counter sweeps over several active sets check the hit flags.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
    localparam int BUS_W = 8;
    localparam int CMP_W = 12;
    localparam int FLK_W = 4;
    localparam int REG_W = 2 * BUS_W;
    localparam int NCMP  = 4;
    localparam int ADR_W = 4;

    typedef enum logic [1:0] {
        SEL_RA = 2'd0,
        SEL_RB = 2'd1,
        SEL_SA = 2'd2,
        SEL_SB = 2'd3
    } cmp_sel_e;

    typedef struct packed {
        logic fifty;
        logic alock;
        logic lock;
    } cfg_t;

    typedef struct packed {
        logic             valid;
        cmp_sel_e         sel;
        logic [REG_W-1:0] value;
    } wr_evt_t;

    typedef logic [NCMP-1:0][CMP_W-1:0] cmp_arr_t;

    function automatic cfg_t unpack_cfg(input logic [BUS_W-1:0] b);
        cfg_t c;
        c.lock  = b[0];
        c.alock = b[1];
        c.fifty = b[2];
        return c;
    endfunction

    function automatic logic is_free(input cfg_t c);
        return !c.lock && !c.alock;
    endfunction
endpackage

// File: rtl/cmpu_bus.sv
module cmpu_bus
    import cmpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ADR_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output wr_evt_t          evt,
    output logic             cfg_we,
    output cfg_t             cfg_new
);
    logic [BUS_W-1:0] temp_q;
    logic             is_cfg;
    logic             is_hi;

    assign is_cfg = addr[ADR_W-1];
    assign is_hi  = addr[0];

    always_ff @(posedge clk) begin
        if (rst)
            temp_q <= '0;
        else if (we && !is_cfg && is_hi)
            temp_q <= wdata;
    end

    always_comb begin
        evt.valid = we && !is_cfg && !is_hi;
        evt.sel   = cmp_sel_e'(addr[2:1]);
        evt.value = {temp_q, wdata};
        cfg_we    = we && is_cfg;
        cfg_new   = unpack_cfg(wdata);
    end
endmodule

// File: rtl/cmpu_stage.sv
module cmpu_stage
    import cmpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_evt_t          evt,
    input  logic             cfg_we,
    input  cfg_t             cfg_new,
    input  logic             cyc_end,
    output cmp_arr_t         stg_cmp,
    output logic [FLK_W-1:0] stg_flank,
    output cfg_t             cfg,
    output logic             commit
);
    cmp_arr_t         cmp_q;
    logic [FLK_W-1:0] flank_q;
    cfg_t             cfg_q;
    logic             rb_last_q;
    logic             rb_last_d;

    // end-of-cycle mode wins over hold
    always_comb begin
        if (cfg_q.alock)
            commit = cyc_end && rb_last_q;
        else
            commit = !cfg_q.lock;
    end

    always_comb begin
        rb_last_d = commit ? 1'b0 : rb_last_q;
        if (evt.valid)
            rb_last_d = (evt.sel == SEL_RB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q     <= '0;
            flank_q   <= '0;
            cfg_q     <= '0;
            rb_last_q <= 1'b0;
        end else begin
            rb_last_q <= rb_last_d;
            if (cfg_we)
                cfg_q <= cfg_new;
            if (evt.valid) begin
                cmp_q[evt.sel] <= evt.value[CMP_W-1:0];
                if (evt.sel == SEL_RB)
                    flank_q <= evt.value[REG_W-1 -: FLK_W];
            end
        end
    end

    assign stg_cmp   = cmp_q;
    assign stg_flank = flank_q;
    assign cfg       = cfg_q;

    a_r8_rb_write_arms: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.sel == SEL_RB) |=> rb_last_q);
endmodule

// File: rtl/cmpu_active.sv
module cmpu_active
    import cmpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  cfg_t             cfg,
    input  logic             cyc_end,
    input  cmp_arr_t         stg_cmp,
    input  logic [FLK_W-1:0] stg_flank,
    output cmp_arr_t         act_cmp,
    output logic [FLK_W-1:0] act_flank
);
    cmp_arr_t         act_q;
    logic [FLK_W-1:0] flank_q;
    cmp_arr_t         src;

    // symmetric mode: rising slots mirror the falling ones
    always_comb begin
        src = stg_cmp;
        if (cfg.fifty) begin
            src[SEL_RA] = stg_cmp[SEL_RB];
            src[SEL_SA] = stg_cmp[SEL_SB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            flank_q <= '0;
        end else if (commit) begin
            act_q   <= src;
            flank_q <= stg_flank;
        end
    end

    assign act_cmp   = act_q;
    assign act_flank = flank_q;

    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (cfg.lock && !cfg.alock) |=> ($stable(act_q) && $stable(flank_q)));

    a_r7_only_at_strobe: assert property (@(posedge clk) disable iff (rst)
        (cfg.alock && !cyc_end) |=> ($stable(act_q) && $stable(flank_q)));

    a_r10_mirror: assert property (@(posedge clk) disable iff (rst)
        (commit && cfg.fifty) |=>
            (act_q[SEL_RA] == act_q[SEL_RB] && act_q[SEL_SA] == act_q[SEL_SB]));
endmodule

// File: rtl/cmpu_match.sv
module cmpu_match
    import cmpu_pkg::*;
(
    input  logic [CMP_W-1:0] cnt,
    input  cmp_arr_t         act_cmp,
    output logic [NCMP-1:0]  hit
);
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i] = (cnt == act_cmp[i]);
    end
endmodule

// File: rtl/pwm_cmp_update.sv
module pwm_cmp_update
    import cmpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              cyc_end,
    input  logic [CMP_W-1:0]  cnt,
    output logic [CMP_W-1:0]  act_ra,
    output logic [CMP_W-1:0]  act_rb,
    output logic [CMP_W-1:0]  act_sa,
    output logic [CMP_W-1:0]  act_sb,
    output logic [FLK_W-1:0]  flank,
    output logic [NCMP-1:0]   hit
);
    wr_evt_t          evt;
    logic             cfg_we;
    cfg_t             cfg_new;
    cfg_t             cfg;
    logic             commit;
    cmp_arr_t         stg_cmp;
    logic [FLK_W-1:0] stg_flank;
    cmp_arr_t         act_cmp;

    cmpu_bus u_bus (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .evt(evt), .cfg_we(cfg_we), .cfg_new(cfg_new)
    );

    cmpu_stage u_stage (
        .clk(clk), .rst(rst), .evt(evt), .cfg_we(cfg_we), .cfg_new(cfg_new),
        .cyc_end(cyc_end), .stg_cmp(stg_cmp), .stg_flank(stg_flank),
        .cfg(cfg), .commit(commit)
    );

    cmpu_active u_act (
        .clk(clk), .rst(rst), .commit(commit), .cfg(cfg), .cyc_end(cyc_end),
        .stg_cmp(stg_cmp), .stg_flank(stg_flank),
        .act_cmp(act_cmp), .act_flank(flank)
    );

    cmpu_match u_match (.cnt(cnt), .act_cmp(act_cmp), .hit(hit));

    assign act_ra = act_cmp[SEL_RA];
    assign act_rb = act_cmp[SEL_RB];
    assign act_sa = act_cmp[SEL_SA];
    assign act_sb = act_cmp[SEL_SB];
endmodule

// File: tb/sim_pwm_cmp_update.sv
module sim_pwm_cmp_update;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wd = '0;
    logic        eoc = 1'b0;
    logic [11:0] cnt = '0;
    logic [11:0] ra, rb, sa, sb;
    logic [3:0]  fl;
    logic [3:0]  hit;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_cmp_update u0 (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
        .cyc_end(eoc), .cnt(cnt), .act_ra(ra), .act_rb(rb), .act_sa(sa),
        .act_sb(sb), .flank(fl), .hit(hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_set(input string req, input logic [11:0] e_ra, input logic [11:0] e_rb,
                           input logic [11:0] e_sa, input logic [11:0] e_sb, input logic [3:0] e_fl);
        chk({req, " ra"}, ra, e_ra);
        chk({req, " rb"}, rb, e_rb);
        chk({req, " sa"}, sa, e_sa);
        chk({req, " sb"}, sb, e_sb);
        chk({req, " flank"}, fl, e_fl);
    endtask

    task automatic bw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wr16(input logic [1:0] idx, input logic [15:0] v);
        bw({1'b0, idx, 1'b1}, v[15:8]);
        bw({1'b0, idx, 1'b0}, v[7:0]);
    endtask

    task automatic cfgw(input logic [7:0] b);
        bw(4'b1000, b);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); eoc = 1'b1;
        @(negedge clk); eoc = 1'b0;
    endtask

    // R11: exhaustive counter sweep against the current active set
    task automatic sweep();
        int errs = 0;
        logic [3:0] e;
        for (int c = 0; c < 4096; c++) begin
            cnt = c[11:0];
            #1;
            e = {cnt == sb, cnt == sa, cnt == rb, cnt == ra};
            total++;
            if (hit !== e) begin
                bad++; errs++;
                if (errs < 5) $display("FAIL R11 cnt=%0h actual=%0h expected=%0h", cnt, hit, e);
            end
        end
        cnt = '0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk_set("R1", 0, 0, 0, 0, 0);
        chk("R1 hit", hit, 4'hF);

        // R2/R4 free mode write latency
        wr16(2'd0, 16'h0123);
        chk("R4 not yet", ra, 12'h000);
        tick(1);
        chk("R4 R2 ra", ra, 12'h123);

        // R3 shared temp byte
        bw(4'b0001, 8'hAB);
        tick(2);
        chk_set("R3 hi alone", 12'h123, 0, 0, 0, 0);
        bw(4'b0110, 8'hCD);
        tick(1);
        chk("R3 shared sb", sb, 12'hBCD);
        bw(4'b0100, 8'h11);
        tick(1);
        chk("R3 kept sa", sa, 12'hB11);

        // R5 flank field sweep
        for (int f = 0; f < 16; f++) begin
            wr16(2'd1, {f[3:0], 4'(f), 8'h5A});
            tick(1);
            chk("R5 rb", rb, {4'(f), 8'h5A});
            chk("R5 flank", fl, f[3:0]);
        end
        wr16(2'd0, 16'hF456);
        tick(1);
        chk("R5 ra 12b", ra, 12'h456);
        chk("R5 flank kept", fl, 4'hF);
        sweep();

        // R6 hold
        cfgw(8'h01);
        wr16(2'd0, 16'h0A01);
        wr16(2'd1, 16'h3A02);
        wr16(2'd2, 16'h0A03);
        wr16(2'd3, 16'h0A04);
        tick(3);
        chk_set("R6 held", 12'h456, 12'hF5A, 12'hB11, 12'hBCD, 4'hF);
        strobe();
        chk_set("R6 strobe ignored", 12'h456, 12'hF5A, 12'hB11, 12'hBCD, 4'hF);
        cfgw(8'h00);
        chk_set("R6 release edge", 12'h456, 12'hF5A, 12'hB11, 12'hBCD, 4'hF);
        tick(1);
        chk_set("R6 released", 12'hA01, 12'hA02, 12'hA03, 12'hA04, 4'h3);
        sweep();

        // R7 end-of-cycle mode
        cfgw(8'h02);
        wr16(2'd0, 16'h0B01);
        tick(1);
        chk("R7 no early", ra, 12'hA01);
        strobe();
        chk("R7 no rb write", ra, 12'hA01);
        wr16(2'd2, 16'h0B03);
        wr16(2'd1, 16'h5B02);
        tick(2);
        chk("R7 wait strobe", rb, 12'hA02);
        strobe();
        chk_set("R7 committed", 12'hB01, 12'hB02, 12'hB03, 12'hA04, 4'h5);

        // R8 later write cancels
        wr16(2'd1, 16'h6C02);
        wr16(2'd0, 16'h0C01);
        strobe();
        chk_set("R8 cancelled", 12'hB01, 12'hB02, 12'hB03, 12'hA04, 4'h5);
        wr16(2'd1, 16'h7C12);
        strobe();
        chk_set("R8 rearmed", 12'hC01, 12'hC12, 12'hB03, 12'hA04, 4'h7);

        // R9 end-of-cycle wins over hold
        cfgw(8'h03);
        wr16(2'd3, 16'h0D04);
        wr16(2'd1, 16'h8D02);
        tick(2);
        chk("R9 waits", sb, 12'hA04);
        strobe();
        chk_set("R9 commit", 12'hC01, 12'hD02, 12'hB03, 12'hD04, 4'h8);

        // R10 symmetric mode, free
        cfgw(8'h04);
        wr16(2'd0, 16'h0777);
        wr16(2'd1, 16'h92A5);
        wr16(2'd2, 16'h0888);
        wr16(2'd3, 16'h03C3);
        tick(1);
        chk_set("R10 free", 12'h2A5, 12'h2A5, 12'h3C3, 12'h3C3, 4'h9);
        sweep();

        // R10 symmetric with end-of-cycle
        cfgw(8'h06);
        wr16(2'd3, 16'h0200);
        wr16(2'd1, 16'h1100);
        tick(1);
        chk("R10 pending", ra, 12'h2A5);
        strobe();
        chk_set("R10 eoc", 12'h100, 12'h100, 12'h200, 12'h200, 4'h1);
        sweep();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule